// File: doc/BRIEF.md
# Strap-configured host bus decoder

This block sits at the host-bus edge of a display controller. While power-on reset is held, sixteen strap pins are pulled high internally or tied low on the board. At the first clock edge after reset is released, the block samples them into two read-only configuration bytes. The first byte steers host decoding: the BIOS ROM chip select and its window, which I/O port holds the video enable bit, whether the block starts enabled, the bus width, 16-bit I/O support, and how addresses are qualified. The second byte selects an analog test mode and reports a display-type code for the BIOS.

All select outputs are combinational from the effective address and the command strobes. Software reads back both bytes through an index/data port pair. In normal use the board straps fix the behaviour, and the BIOS then toggles the video enable bit.

Top module: `strap_bus_decoder`

## Requirements
- R1: At the first rising clock edge with `rst_n` high, `mad_i[7:0]` is captured as config byte A and `mad_i[15:8]` as config byte B. Neither byte changes after that until the next reset. Before capture, `rom_cs_n`=1 and every other output is 0.
- R2: `rom_cs_n` goes low only when all of these hold: capture is done, `local_bus_i`=1, A[0]=1, the command qualifier is met and the address is in the ROM window. It does not depend on the video enable bit.
- R3: The ROM window is 64 KB. It is 0xE0000–0xEFFFF when A[1]=1 and A[2]=0, and 0xC0000–0xCFFFF in every other case.
- R4: The enable port is I/O 0x46E8 when A[4]=0 and 0x03C3 when A[4]=1, compared on address bits [15:0]. An I/O write there stores `din_i[0]` as the enable bit at the clock edge, whether or not the block is enabled. A write to the other port leaves the enable bit unchanged.
- R5: At capture the enable bit is loaded with the inverse of the strap on `mad_i[5]`.
- R6: `mem_sel_o` is high when the block is enabled, the address is in 0xA0000–0xBFFFF and the qualifier is met. `io_sel_o` is high when the block is enabled, I/O address bits [15:0] are in 0x3B0–0x3DF and the qualifier is met.
- R7: With A[7]=0, decoding uses `addr_i` as presented. The qualifier then needs `memr_n` low for the ROM, `memr_n` or `memw_n` low for video memory, and `ior_n` or `iow_n` low for I/O. With A[7]=1, decoding uses the address held at the last clock edge with `ale_i`=1, and the selects need no strobe. Register reads and writes always need their strobe.
- R8: `bus16_o` equals A[6] after capture. `mem16_o` is `mem_sel_o` AND A[6]. `io16_o` is `io_sel_o` AND NOT A[3].
- R9: While enabled, an I/O write to 0x3C4 stores `din_i` as the index. A read (`ior_n` low) of 0x3C4 returns the index. A read of 0x3C5 returns B at index 0xCF, A at index 0xCE and 0x00 at any other index. `rd_en_o` is high only during these reads, and `rd_data_o` is 0 at all other times.
- R10: Writes to 0x3C5 have no effect: later reads of both config bytes are unchanged.
- R11: `disp_type_o` is B[7:4]. B[2:0]=110 raises `test_mclk_o`, 101 raises `test_vclk_o` and 011 raises `test_dac_o`. Any other code raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mad_i | input | 16 | Strap pins, sampled once after reset |
| local_bus_i | input | 1 | Local-bus interface selected |
| ale_i | input | 1 | Address latch enable |
| addr_i | input | 20 | Host address |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| din_i | input | 8 | I/O write data |
| rom_cs_n | output | 1 | BIOS ROM chip select, active low |
| mem_sel_o | output | 1 | Video memory access accepted |
| io_sel_o | output | 1 | Video I/O access accepted |
| mem16_o | output | 1 | 16-bit memory cycle |
| io16_o | output | 1 | 16-bit I/O cycle |
| bus16_o | output | 1 | Host bus is 16 bits wide |
| rd_en_o | output | 1 | Block drives read data |
| rd_data_o | output | 8 | Read data |
| test_mclk_o | output | 1 | Memory clock test mode |
| test_vclk_o | output | 1 | Video clock test mode |
| test_dac_o | output | 1 | DAC test mode |
| disp_type_o | output | 4 | Display-type code |

## Verification
The assertions assume that `rst_n` is released away from a rising clock edge. They also assume that the strobes change only between edges, so a write seen at an edge has been held for that whole cycle. The bench drives every input one nanosecond after a falling edge. It holds the straps steady through release and then deliberately scrambles them, so a late sample would show up. Each bus cycle presents its address with `ale_i` high for one clock, then the strobe for one clock, which satisfies both decode modes.

// File: rtl/strap_dec_pkg.sv
package strap_dec_pkg;
  localparam int unsigned STRAP_W = 16;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned IO_W    = 16;
  localparam int unsigned N_TEST  = 3;

  localparam logic [ADDR_W-1:0] VMEM_LO  = 20'hA0000;
  localparam logic [ADDR_W-1:0] VMEM_HI  = 20'hBFFFF;
  localparam logic [ADDR_W-1:0] ROM_C    = 20'hC0000;
  localparam logic [ADDR_W-1:0] ROM_E    = 20'hE0000;
  localparam logic [IO_W-1:0]   IO_LO    = 16'h03B0;
  localparam logic [IO_W-1:0]   IO_HI    = 16'h03DF;
  localparam logic [IO_W-1:0]   EN_PORT0 = 16'h46E8;
  localparam logic [IO_W-1:0]   EN_PORT1 = 16'h03C3;
  localparam logic [IO_W-1:0]   IDX_PORT = 16'h03C4;
  localparam logic [IO_W-1:0]   DAT_PORT = 16'h03C5;
  localparam logic [CFG_W-1:0]  IDX_CFGA = 8'hCE;
  localparam logic [CFG_W-1:0]  IDX_CFGB = 8'hCF;

  typedef struct packed {
    logic addr_latch_mode;
    logic wide_bus;
    logic boot_off;
    logic port_sel;
    logic io16_off;
    logic rom_c_base;
    logic rom_move;
    logic rom_cs_on;
  } cfg_a_t;

  typedef struct packed {
    logic [3:0] disp;
    logic       spare;
    logic [2:0] test;
  } cfg_b_t;

  function automatic logic [2:0] test_code(input int unsigned k);
    case (k)
      0:       return 3'b110;
      1:       return 3'b101;
      default: return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mad_i,
  output logic [W-1:0] straps_o,
  output logic         cap_o
);
  logic [W-1:0] st_q, st_d;
  logic         cap_q, cap_d;
  logic         load_en;

  always_comb begin
    load_en = !cap_q;
    cap_d   = 1'b1;
    st_d    = load_en ? mad_i : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      st_q  <= '1;
    end else begin
      cap_q <= cap_d;
      st_q  <= st_d;
    end
  end

  assign straps_o = st_q;
  assign cap_o    = cap_q;
endmodule

// File: rtl/addr_stage.sv
module addr_stage #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_mode,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o
);
  logic [AW-1:0] la_q, la_d;

  always_comb begin
    la_d = ale_i ? addr_i : la_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) la_q <= '0;
    else        la_q <= la_d;
  end

  assign eff_addr_o = latch_mode ? la_q : addr_i;
endmodule

// File: rtl/window_decode.sv
module window_decode
  import strap_dec_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned IW = IO_W
) (
  input  logic          cap,
  input  logic          enable,
  input  logic          local_bus,
  input  logic          latch_mode,
  input  logic          wide_bus,
  input  logic          port_sel,
  input  logic          io16_off,
  input  logic          rom_c_base,
  input  logic          rom_move,
  input  logic          rom_cs_on,
  input  logic [AW-1:0] eff_addr,
  input  logic          memr_n,
  input  logic          memw_n,
  input  logic          ior_n,
  input  logic          iow_n,
  output logic          rom_cs_n,
  output logic          mem_sel,
  output logic          io_sel,
  output logic          mem16,
  output logic          io16,
  output logic          bus16,
  output logic          en_wr,
  output logic          idx_wr,
  output logic          idx_rd,
  output logic          dat_rd
);
  localparam int unsigned WIN_LSB = 16;

  logic [IW-1:0] io_addr;
  logic [IW-1:0] port_addr;
  logic [AW-1:0] rom_base;
  logic          rom_hit, vmem_hit, io_hit;
  logic          q_rom, q_mem, q_io;

  always_comb begin
    io_addr   = eff_addr[IW-1:0];
    port_addr = port_sel ? EN_PORT1 : EN_PORT0;
    rom_base  = (rom_move && !rom_c_base) ? ROM_E : ROM_C;
    rom_hit   = (eff_addr[AW-1:WIN_LSB] == rom_base[AW-1:WIN_LSB]);
    vmem_hit  = (eff_addr >= VMEM_LO) && (eff_addr <= VMEM_HI);
    io_hit    = (io_addr >= IO_LO) && (io_addr <= IO_HI);

    q_rom = latch_mode || !memr_n;
    q_mem = latch_mode || !memr_n || !memw_n;
    q_io  = latch_mode || !ior_n || !iow_n;

    rom_cs_n = !(cap && local_bus && rom_cs_on && rom_hit && q_rom);
    mem_sel  = cap && enable && vmem_hit && q_mem;
    io_sel   = cap && enable && io_hit && q_io;
    mem16    = mem_sel && wide_bus;
    io16     = io_sel && !io16_off;
    bus16    = cap && wide_bus;

    en_wr  = cap && !iow_n && (io_addr == port_addr);
    idx_wr = cap && enable && !iow_n && (io_addr == IDX_PORT);
    idx_rd = cap && enable && !ior_n && (io_addr == IDX_PORT);
    dat_rd = cap && enable && !ior_n && (io_addr == DAT_PORT);
  end
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import strap_dec_pkg::*;
#(
  parameter int unsigned DW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          boot_off_raw,
  input  logic          en_wr,
  input  logic          idx_wr,
  input  logic          idx_rd,
  input  logic          dat_rd,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] cfg_a,
  input  logic [DW-1:0] cfg_b,
  output logic          enable_o,
  output logic          rd_en_o,
  output logic [DW-1:0] rd_data_o
);
  logic          en_q, en_d;
  logic [DW-1:0] idx_q, idx_d;
  logic [DW-1:0] dat_mux;

  always_comb begin
    en_d = en_q;
    if (!cap)       en_d = !boot_off_raw;
    else if (en_wr) en_d = din[0];
    idx_d = idx_wr ? din : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      en_q  <= en_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    if (idx_q == IDX_CFGB)      dat_mux = cfg_b;
    else if (idx_q == IDX_CFGA) dat_mux = cfg_a;
    else                        dat_mux = '0;
    rd_en_o = idx_rd || dat_rd;
    if (idx_rd)      rd_data_o = idx_q;
    else if (dat_rd) rd_data_o = dat_mux;
    else             rd_data_o = '0;
  end

  assign enable_o = en_q;
endmodule

// File: rtl/strap_bus_decoder.sv
module strap_bus_decoder
  import strap_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRAP_W-1:0] mad_i,
  input  logic              local_bus_i,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [CFG_W-1:0]  din_i,
  output logic              rom_cs_n,
  output logic              mem_sel_o,
  output logic              io_sel_o,
  output logic              mem16_o,
  output logic              io16_o,
  output logic              bus16_o,
  output logic              rd_en_o,
  output logic [CFG_W-1:0]  rd_data_o,
  output logic              test_mclk_o,
  output logic              test_vclk_o,
  output logic              test_dac_o,
  output logic [3:0]        disp_type_o
);
  localparam int unsigned BOOT_BIT = 5;

  logic [STRAP_W-1:0] straps;
  logic               cap;
  logic               en_q_w;
  cfg_a_t             cfg_a;
  cfg_b_t             cfg_b;
  logic [ADDR_W-1:0]  eff_addr;
  logic               en_wr, idx_wr, idx_rd, dat_rd;
  logic [N_TEST-1:0]  test_hit;

  strap_capture #(.W(STRAP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .mad_i(mad_i), .straps_o(straps), .cap_o(cap)
  );

  assign cfg_a = cfg_a_t'(straps[CFG_W-1:0]);
  assign cfg_b = cfg_b_t'(straps[STRAP_W-1:CFG_W]);

  addr_stage #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .latch_mode(cfg_a.addr_latch_mode),
    .ale_i(ale_i), .addr_i(addr_i), .eff_addr_o(eff_addr)
  );

  window_decode #(.AW(ADDR_W), .IW(IO_W)) u_dec (
    .cap(cap), .enable(en_q_w), .local_bus(local_bus_i),
    .latch_mode(cfg_a.addr_latch_mode), .wide_bus(cfg_a.wide_bus),
    .port_sel(cfg_a.port_sel), .io16_off(cfg_a.io16_off),
    .rom_c_base(cfg_a.rom_c_base), .rom_move(cfg_a.rom_move),
    .rom_cs_on(cfg_a.rom_cs_on), .eff_addr(eff_addr),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .rom_cs_n(rom_cs_n), .mem_sel(mem_sel_o), .io_sel(io_sel_o),
    .mem16(mem16_o), .io16(io16_o), .bus16(bus16_o),
    .en_wr(en_wr), .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_rd(dat_rd)
  );

  ctrl_regs #(.DW(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap(cap), .boot_off_raw(mad_i[BOOT_BIT]),
    .en_wr(en_wr), .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_rd(dat_rd),
    .din(din_i), .cfg_a(straps[CFG_W-1:0]), .cfg_b(straps[STRAP_W-1:CFG_W]),
    .enable_o(en_q_w), .rd_en_o(rd_en_o), .rd_data_o(rd_data_o)
  );

  for (genvar g = 0; g < N_TEST; g++) begin : g_test
    assign test_hit[g] = cap && (cfg_b.test == test_code(g));
  end

  assign test_mclk_o = test_hit[0];
  assign test_vclk_o = test_hit[1];
  assign test_dac_o  = test_hit[2];
  assign disp_type_o = cap ? cfg_b.disp : 4'h0;
endmodule

// File: rtl/strap_bus_decoder_chk.sv
module strap_bus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cap,
  input logic        enable,
  input logic [15:0] straps,
  input logic        iow_n,
  input logic        ior_n,
  input logic        rom_cs_n,
  input logic        mem_sel_o,
  input logic        io_sel_o,
  input logic        mem16_o,
  input logic        io16_o,
  input logic        rd_en_o,
  input logic        test_mclk_o,
  input logic        test_vclk_o,
  input logic        test_dac_o
);
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap) |-> $stable(straps));

  // R1
  idle_before_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |-> (rom_cs_n && !mem_sel_o && !io_sel_o && !rd_en_o));

  // R5
  boot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap) |-> (enable == !straps[5]));

  // R4
  enable_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap) && !$stable(enable)) |-> !$past(iow_n));

  // R6
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_o |-> enable);

  // R6
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel_o |-> enable);

  // R8
  io16_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io16_o |-> io_sel_o);

  // R8
  mem16_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem16_o |-> mem_sel_o);

  // R9
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !ior_n);

  // R11
  test_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_mclk_o, test_vclk_o, test_dac_o}));
endmodule

bind strap_bus_decoder strap_bus_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cap(cap), .enable(en_q_w), .straps(straps),
  .iow_n(iow_n), .ior_n(ior_n), .rom_cs_n(rom_cs_n), .mem_sel_o(mem_sel_o),
  .io_sel_o(io_sel_o), .mem16_o(mem16_o), .io16_o(io16_o), .rd_en_o(rd_en_o),
  .test_mclk_o(test_mclk_o), .test_vclk_o(test_vclk_o), .test_dac_o(test_dac_o)
);

// File: tb/test_strap_bus_decoder.sv
`timescale 1ns/1ps
module test_strap_bus_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mad_i;
  logic        local_bus_i, ale_i;
  logic [19:0] addr_i;
  logic        memr_n, memw_n, ior_n, iow_n;
  logic [7:0]  din_i;
  logic        rom_cs_n, mem_sel_o, io_sel_o, mem16_o, io16_o, bus16_o, rd_en_o;
  logic [7:0]  rd_data_o;
  logic        test_mclk_o, test_vclk_o, test_dac_o;
  logic [3:0]  disp_type_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  strap_bus_decoder i_strap_bus_decoder (.*);

  // behavioural reference state
  bit       m_cap, m_en;
  bit [7:0] m_a, m_b, m_idx;
  bit [19:0] m_la;

  function automatic bit [19:0] m_eff();
    return m_a[7] ? m_la : addr_i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cap = 0; m_en = 0; m_a = 8'hFF; m_b = 8'hFF; m_idx = 0; m_la = 0;
    end else begin
      bit [15:0] io;
      io = m_eff() & 20'h0FFFF;
      if (!m_cap) begin
        m_a = mad_i[7:0]; m_b = mad_i[15:8]; m_en = !mad_i[5]; m_cap = 1;
      end else if (!iow_n) begin
        if (io == (m_a[4] ? 16'h03C3 : 16'h46E8)) m_en = din_i[0];
        else if (m_en && io == 16'h03C4) m_idx = din_i;
      end
      if (ale_i) m_la = addr_i;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      bit [19:0] e; bit [15:0] io; bit er, em, ei, rd; bit [7:0] rdd; bit [3:0] base;
      e = m_eff(); io = e[15:0];
      er = 1;
      base = (m_a[1] && !m_a[2]) ? 4'hE : 4'hC;
      if (m_cap && local_bus_i && m_a[0] && (m_a[7] || !memr_n) && e[19:16] == base) er = 0;
      em = m_cap && m_en && e >= 20'hA0000 && e <= 20'hBFFFF && (m_a[7] || !memr_n || !memw_n);
      ei = m_cap && m_en && io >= 16'h03B0 && io <= 16'h03DF && (m_a[7] || !ior_n || !iow_n);
      rd = m_cap && m_en && !ior_n && (io == 16'h03C4 || io == 16'h03C5);
      rdd = 0;
      if (rd) rdd = (io == 16'h03C4) ? m_idx : (m_idx == 8'hCF) ? m_b : (m_idx == 8'hCE) ? m_a : 8'h00;
      chk(rom_cs_n, er, "R2 R3 rom_cs_n");
      chk(mem_sel_o, em, "R6 R7 mem_sel");
      chk(io_sel_o, ei, "R6 io_sel");
      chk(mem16_o, em && m_a[6], "R8 mem16");
      chk(io16_o, ei && !m_a[3], "R8 io16");
      chk(bus16_o, m_cap && m_a[6], "R8 bus16");
      chk(rd_en_o, rd, "R9 rd_en");
      chk(rd_data_o, rdd, "R9 R10 rd_data");
      chk(test_mclk_o, m_cap && m_b[2:0] == 3'b110, "R11 mclk");
      chk(test_vclk_o, m_cap && m_b[2:0] == 3'b101, "R11 vclk");
      chk(test_dac_o, m_cap && m_b[2:0] == 3'b011, "R11 dac");
      chk(disp_type_o, m_cap ? m_b[7:4] : 0, "R11 disp");
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    ale_i = 0; memr_n = 1; memw_n = 1; ior_n = 1; iow_n = 1;
  endtask

  // cmd bits: [3]=memr [2]=memw [1]=ior [0]=iow
  task automatic bus(input bit [19:0] a, input bit [3:0] cmd, input bit [7:0] d);
    @(negedge clk); #1;
    addr_i = a; ale_i = 1; din_i = d; memr_n = 1; memw_n = 1; ior_n = 1; iow_n = 1;
    @(negedge clk); #1;
    ale_i = 0; memr_n = !cmd[3]; memw_n = !cmd[2]; ior_n = !cmd[1]; iow_n = !cmd[0];
    #1;
  endtask

  task automatic boot(input bit [15:0] straps);
    rst_n = 0; mad_i = straps;
    repeat (3) @(negedge clk);
    #2;
    chk(rom_cs_n, 1, "R1 reset rom_cs_n");
    chk(rd_en_o, 0, "R1 reset rd_en");
    chk(disp_type_o, 0, "R1 reset disp");
    rst_n = 1;
    @(negedge clk); #1;
    mad_i = ~straps;
    idle();
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    local_bus_i = 1; ale_i = 0; addr_i = 0; din_i = 0;
    memr_n = 1; memw_n = 1; ior_n = 1; iow_n = 1;

    // all straps pulled high: latched mode, boot disabled, port 3C3
    boot(16'hFFFF);
    chk(disp_type_o, 4'hF, "R1 strap held after scramble");
    bus(20'hC1234, 4'b1000, 0); chk(rom_cs_n, 0, "R2 rom in C window");
    bus(20'hA0000, 4'b1000, 0); chk(mem_sel_o, 0, "R5 boot disabled");
    bus(20'h003C3, 4'b0001, 8'h01);
    bus(20'hA0000, 4'b1000, 0); chk(mem_sel_o, 1, "R4 enabled via 3C3");
    chk(mem16_o, 1, "R8 mem16 wide");
    bus(20'h003C4, 4'b0001, 8'hCF);
    bus(20'h003C5, 4'b0010, 0); chk(rd_data_o, 8'hFF, "R9 read cfg B");
    bus(20'h003C5, 4'b0001, 8'h00);
    bus(20'h003C5, 4'b0010, 0); chk(rd_data_o, 8'hFF, "R10 cfg B unchanged");
    bus(20'h003C4, 4'b0001, 8'hCE);
    bus(20'h003C5, 4'b0010, 0); chk(rd_data_o, 8'hFF, "R9 read cfg A");
    bus(20'h003C4, 4'b0010, 0); chk(rd_data_o, 8'hCE, "R9 read index");
    bus(20'hA1000, 4'b0000, 0); chk(mem_sel_o, 1, "R7 latched no strobe");
    idle();

    // SA mode, 8-bit, boot enabled, port 46E8, MCLK test, display 6
    boot(16'h6601);
    chk(test_mclk_o, 1, "R11 mclk");
    chk(disp_type_o, 4'h6, "R11 disp 6");
    bus(20'hC8000, 4'b1000, 0); chk(rom_cs_n, 0, "R3 C window");
    bus(20'hE0000, 4'b1000, 0); chk(rom_cs_n, 1, "R3 E not decoded");
    bus(20'hC0000, 4'b0100, 0); chk(rom_cs_n, 1, "R7 rom needs memr");
    bus(20'hA0000, 4'b0000, 0); chk(mem_sel_o, 0, "R7 no strobe SA");
    bus(20'hA0000, 4'b1000, 0); chk(mem_sel_o, 1, "R5 boot enabled");
    chk(mem16_o, 0, "R8 narrow bus");
    bus(20'h003D4, 4'b0010, 0); chk(io16_o, 1, "R8 io16");
    bus(20'h046E8, 4'b0001, 8'h00);
    bus(20'hA0000, 4'b1000, 0); chk(mem_sel_o, 0, "R4 disabled via 46E8");
    bus(20'hC0000, 4'b1000, 0); chk(rom_cs_n, 0, "R2 rom ignores enable");
    bus(20'h003C3, 4'b0001, 8'h01);
    bus(20'hA0000, 4'b1000, 0); chk(mem_sel_o, 0, "R4 wrong port ignored");
    bus(20'h046E8, 4'b0001, 8'h01);
    bus(20'hB0000, 4'b0100, 0); chk(mem_sel_o, 1, "R4 re-enabled");
    idle();

    // relocated window at E, VCLK test
    boot(16'h5503);
    chk(test_vclk_o, 1, "R11 vclk");
    bus(20'hE4000, 4'b1000, 0); chk(rom_cs_n, 0, "R3 E window");
    bus(20'hC0000, 4'b1000, 0); chk(rom_cs_n, 1, "R3 C not decoded");
    local_bus_i = 0;
    bus(20'hE4000, 4'b1000, 0); chk(rom_cs_n, 1, "R2 needs local bus");
    local_bus_i = 1;
    idle();

    // relocation bit set with C base, DAC test
    boot(16'h3B07);
    chk(test_dac_o, 1, "R11 dac");
    bus(20'hC4000, 4'b1000, 0); chk(rom_cs_n, 0, "R3 C relocated");
    bus(20'hE0000, 4'b1000, 0); chk(rom_cs_n, 1, "R3 E off");
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule